// File: doc/BRIEF.md
# Page Write Buffer and Commit Controller

This block sits behind a serial-memory protocol engine and turns a stream of received write bytes into a page update of a 2K x 8 register array. The protocol engine first presents a memory address with a load strobe. Each data byte it accepts after that arrives on a byte strobe and goes into a 16-entry page buffer with one valid flag per entry. Only the low four address bits advance between bytes, so a burst longer than a page wraps back to the start of the same page and overwrites what was buffered there.

Nothing reaches the array until the protocol engine reports a stop. A stop that finds at least one buffered byte, with the protect pin never seen high since the address load and the supply flag good, starts a timed write cycle of a parameterised number of clocks. During that cycle the busy flag is high and every strobe is ignored; the protocol engine uses the flag to withhold acknowledges. The buffered bytes are written into the array at the end of the cycle. The current-address output is the page of the last load joined to the in-page offset that follows the last byte, so it wraps inside the page. A combinational read port reads the array at any time, whatever the protect pin does.

Top module: `pgw_ctrl`

## Requirements
- R1: After reset, busy is 0, cur_addr is 0 and every array location reads 8'hFF.
- R2: A load strobe while not busy sets cur_addr to load_addr at the next clock edge, opens a write transaction and empties the page buffer.
- R3: Each byte strobe inside an open transaction buffers byte_data at location {page, offset}, where the page is load_addr[10:4] of the last load and the offset starts at load_addr[3:0]. Each such byte raises only the low four bits of cur_addr by one, modulo 16.
- R4: After offset 15 the next byte goes to offset 0 of the same page. A later byte at a buffered offset replaces the earlier one, and cur_addr never leaves the page.
- R5: The array is not changed before a commit. An accepted stop with at least one buffered byte, wp low and supply_ok high raises busy at the next edge. Busy then stays high for exactly WR_CYCLES cycles, and when it falls the buffered locations read the new data while all other locations keep their values.
- R6: While busy is high, load, byte and stop strobes have no effect: cur_addr holds and no byte of that period ever reaches the array.
- R7: If wp is high in any cycle from the load strobe through the stop strobe, the stop starts no write: busy stays 0 and the array keeps its contents.
- R8: If supply_ok is low at the stop strobe, no write starts: busy stays 0 and the array keeps its contents.
- R9: A stop with no byte buffered after the load, such as a dummy write that only sets an address, does not raise busy.
- R10: rd_data equals the array content at rd_addr in the same cycle, also while wp is high and while busy is high.
- R11: Byte and stop strobes outside an open transaction are ignored. A transaction closes at its stop, so bytes sent after a stop without a new load change neither cur_addr nor the array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_load | input | 1 | Strobe: load_addr carries a new memory address |
| load_addr | input | 11 | Memory address for the transaction |
| byte_stb | input | 1 | Strobe: byte_data carries an accepted data byte |
| byte_data | input | 8 | Data byte to buffer |
| stop_stb | input | 1 | Strobe: the bus saw a stop condition |
| wp | input | 1 | Write-protect pin, active high |
| supply_ok | input | 1 | High when the supply is high enough to write |
| busy | output | 1 | Timed write cycle in progress |
| cur_addr | output | 11 | Current address: last page and the offset after the last byte |
| rd_addr | input | 11 | Read port address |
| rd_data | output | 8 | Array content at rd_addr |

## Verification
The commit path is tried with a short burst inside a page, with an 18-byte burst that starts two bytes before the end of a page, and with strobes sent during the busy window. These show the difference between a correct per-page wrap and a carry into the page bits, and between a write that ignores late input and one that takes it. The blocked cases (protect pin high for a single mid-transaction cycle, protect pin high only at the stop, low supply at the stop, an address-only stop, and bytes after a closed transaction) each expect an unchanged array and no busy. This separates a protect pin that is sampled through the whole transaction from one that is read only at the stop. A behavioural model with a queue of pending writes follows every clock, and busy, cur_addr and rd_data are compared against it each cycle.

// File: rtl/pgw_pkg.sv
// Shared sizes for the page write controller.
// Assumes: byte-wide array, power-of-two page and array sizes.
package pgw_pkg;
    localparam int ADDR_W_DEF = 11;  // 2K locations
    localparam int OFS_W_DEF  = 4;   // 16-byte page
    localparam int DATA_W_DEF = 8;
    localparam int WR_CYCLES_DEF = 500000;  // 5 ms at 100 MHz
endpackage

// File: rtl/pgw_page_buf.sv
// Page buffer: one data register and one valid flag per byte lane, plus the
// in-page write offset. A load resets the offset and empties the buffer; a
// byte is written at the offset, which then advances modulo the page size.
// Assumes: ld, clr and wr are pre-qualified by the controller.
module pgw_page_buf #(
    parameter int OFS_W  = 4,
    parameter int DATA_W = 8,
    localparam int NB    = 1 << OFS_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld,
    input  logic [OFS_W-1:0]     ld_ofs,
    input  logic                 clr,
    input  logic                 wr,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [OFS_W-1:0]     ptr,
    output logic [NB-1:0]        vld,
    output logic [NB*DATA_W-1:0] buf_flat
);
    logic [OFS_W-1:0] ptr_q;
    logic [NB-1:0]    vld_q;

    // Offset and valid flags: load, clear, or accept one byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            vld_q <= '0;
        end else if (ld) begin
            ptr_q <= ld_ofs;
            vld_q <= '0;
        end else if (clr) begin
            vld_q <= '0;
        end else if (wr) begin
            vld_q[ptr_q] <= 1'b1;
            ptr_q        <= ptr_q + 1'b1;
        end
    end

    // One data register per lane, written when the offset selects it.
    for (genvar i = 0; i < NB; i++) begin : g_lane
        logic [DATA_W-1:0] dat_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                dat_q <= '0;
            else if (wr && !ld && !clr && ptr_q == OFS_W'(i))
                dat_q <= wr_data;
        end
        assign buf_flat[i*DATA_W +: DATA_W] = dat_q;
    end

    assign ptr = ptr_q;
    assign vld = vld_q;

    AST_LANE_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !ld && !clr) |=> vld_q[$past(ptr_q)]);  // R3
    AST_LOAD_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (vld_q == '0));  // R2
endmodule

// File: rtl/pgw_timer.sv
// Write-cycle timer: go starts a busy window of CNT_MAX cycles; done pulses
// in the last busy cycle so the commit lands on the edge where busy falls.
// Assumes: go is never raised while busy.
module pgw_timer #(
    parameter int CNT_MAX = 500000,
    localparam int CW     = $clog2(CNT_MAX + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic busy,
    output logic done
);
    logic [CW-1:0] cnt_q;
    logic          busy_q;

    // Load on go, count down while busy, drop busy after the last count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (go) begin
            busy_q <= 1'b1;
            cnt_q  <= CW'(CNT_MAX - 1);
        end else if (busy_q) begin
            if (cnt_q == '0)
                busy_q <= 1'b0;
            else
                cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = busy_q;
    assign done = busy_q && (cnt_q == '0);

    AST_BUSY_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cnt_q != '0) |=> busy_q);  // R5
    AST_GO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !busy_q);  // R6
endmodule

// File: rtl/pgw_array.sv
// Storage array: all locations set to ones at reset, valid buffer lanes
// written into one page on commit, combinational read port.
// Assumes: commit lasts one cycle and page is stable while it is high.
module pgw_array #(
    parameter int ADDR_W = 11,
    parameter int OFS_W  = 4,
    parameter int DATA_W = 8,
    localparam int NB     = 1 << OFS_W,
    localparam int DEPTH  = 1 << ADDR_W,
    localparam int PAGE_W = ADDR_W - OFS_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 commit,
    input  logic [PAGE_W-1:0]    page,
    input  logic [NB-1:0]        vld,
    input  logic [NB*DATA_W-1:0] buf_flat,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [DATA_W-1:0]    rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Erase to all ones on reset; write valid lanes of the page on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++)
                mem[a] <= '1;
        end else if (commit) begin
            for (int i = 0; i < NB; i++)
                if (vld[i])
                    mem[{page, OFS_W'(i)}] <= buf_flat[i*DATA_W +: DATA_W];
        end
    end

    // Read port, independent of protection and busy state.
    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/pgw_ctrl.sv
// Page write controller top: qualifies the protocol-engine strobes, tracks
// the open transaction and the protect history, and starts the timed commit.
// Assumes: at most one of addr_load, byte_stb, stop_stb is high per cycle.
module pgw_ctrl #(
    parameter int ADDR_W    = pgw_pkg::ADDR_W_DEF,
    parameter int OFS_W     = pgw_pkg::OFS_W_DEF,
    parameter int DATA_W    = pgw_pkg::DATA_W_DEF,
    parameter int WR_CYCLES = pgw_pkg::WR_CYCLES_DEF,
    localparam int NB     = 1 << OFS_W,
    localparam int PAGE_W = ADDR_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              byte_stb,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              stop_stb,
    input  logic              wp,
    input  logic              supply_ok,
    output logic              busy,
    output logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic              open_q;
    logic              wp_seen_q;
    logic [PAGE_W-1:0] page_q;
    logic              ld, wr, stop_acc, go, clr, done;
    logic [OFS_W-1:0]  ptr;
    logic [NB-1:0]     vld;
    logic [NB*DATA_W-1:0] buf_flat;

    // Strobe qualification: nothing is accepted during the write cycle.
    always_comb begin
        ld       = addr_load && !busy;
        wr       = byte_stb && open_q && !busy;
        stop_acc = stop_stb && open_q && !busy;
        go       = stop_acc && (|vld) && !wp_seen_q && !wp && supply_ok;
        clr      = (stop_acc && !go) || done;
    end

    // Transaction state: open flag, page register and protect history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q    <= 1'b0;
            wp_seen_q <= 1'b0;
            page_q    <= '0;
        end else if (ld) begin
            open_q    <= 1'b1;
            wp_seen_q <= wp;
            page_q    <= load_addr[ADDR_W-1:OFS_W];
        end else if (stop_acc) begin
            open_q    <= 1'b0;
            wp_seen_q <= 1'b0;
        end else if (open_q) begin
            wp_seen_q <= wp_seen_q || wp;
        end
    end

    pgw_page_buf #(.OFS_W(OFS_W), .DATA_W(DATA_W)) i_buf (
        .clk(clk), .rst_n(rst_n), .ld(ld), .ld_ofs(load_addr[OFS_W-1:0]),
        .clr(clr), .wr(wr), .wr_data(byte_data),
        .ptr(ptr), .vld(vld), .buf_flat(buf_flat));

    pgw_timer #(.CNT_MAX(WR_CYCLES)) i_timer (
        .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .done(done));

    pgw_array #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .DATA_W(DATA_W)) i_array (
        .clk(clk), .rst_n(rst_n), .commit(done), .page(page_q), .vld(vld),
        .buf_flat(buf_flat), .rd_addr(rd_addr), .rd_data(rd_data));

    assign cur_addr = {page_q, ptr};

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({addr_load, byte_stb, stop_stb}));  // R2
    AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> cur_addr[ADDR_W-1:OFS_W] == $past(cur_addr[ADDR_W-1:OFS_W]));  // R4
    AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cur_addr));  // R6
    AST_WP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_stb && !busy && (wp || wp_seen_q)) |=> !busy);  // R7
    AST_SUPPLY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_stb && !busy && !supply_ok) |=> !busy);  // R8
    AST_EMPTY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_acc && vld == '0) |=> !busy);  // R9
    AST_CLOSED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && !open_q && !addr_load) |=> $stable(cur_addr));  // R11
endmodule

// File: tb/test_pgw_ctrl.sv
module test_pgw_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WR = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_load = 1'b0;
    logic [10:0] load_addr = '0;
    logic        byte_stb = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        stop_stb = 1'b0;
    logic        wp = 1'b0;
    logic        supply_ok = 1'b1;
    logic        busy;
    logic [10:0] cur_addr;
    logic [10:0] rd_addr = '0;
    logic [7:0]  rd_data;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgw_ctrl #(.WR_CYCLES(WR)) i_pgw_ctrl (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .load_addr(load_addr),
        .byte_stb(byte_stb), .byte_data(byte_data), .stop_stb(stop_stb),
        .wp(wp), .supply_ok(supply_ok), .busy(busy), .cur_addr(cur_addr),
        .rd_addr(rd_addr), .rd_data(rd_data));

    // Behavioural reference: memory image, pending-write queue, counters.
    int m_mem [2048];
    int q_a[$];
    int q_d[$];
    bit m_busy, m_open, m_wp;
    int m_cnt, m_page, m_ptr;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_mem[k]) m_mem[k] = 255;
            q_a.delete(); q_d.delete();
            m_busy = 0; m_open = 0; m_wp = 0; m_cnt = 0; m_page = 0; m_ptr = 0;
        end else if (m_busy) begin
            if (m_cnt == 1) begin
                foreach (q_a[k]) m_mem[q_a[k]] = q_d[k];
                q_a.delete(); q_d.delete();
                m_busy = 0;
            end else m_cnt--;
        end else if (addr_load) begin
            m_open = 1; m_page = load_addr / 16; m_ptr = load_addr % 16;
            m_wp = wp; q_a.delete(); q_d.delete();
        end else if (m_open) begin
            if (byte_stb) begin
                q_a.push_back(m_page * 16 + m_ptr); q_d.push_back(byte_data);
                m_ptr = (m_ptr + 1) % 16;
                m_wp = m_wp || wp;
            end else if (stop_stb) begin
                m_open = 0;
                if (q_a.size() > 0 && !(m_wp || wp) && supply_ok) begin
                    m_busy = 1; m_cnt = WR;
                end else begin
                    q_a.delete(); q_d.delete();
                end
                m_wp = 0;
            end else m_wp = m_wp || wp;
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Advance one cycle, then compare outputs with the model away from the edge.
    task automatic tick();
        @(negedge clk);
        if (cmp_on) begin
            chk("R5 busy vs model", int'(busy), int'(m_busy));
            chk("R3 cur_addr vs model", int'(cur_addr), m_page * 16 + m_ptr);
            chk("R10 rd_data vs model", int'(rd_data), m_mem[rd_addr]);
        end
    endtask

    task automatic do_load(int a);
        addr_load = 1'b1; load_addr = 11'(a); tick(); addr_load = 1'b0;
    endtask
    task automatic do_byte(int d);
        byte_stb = 1'b1; byte_data = 8'(d); tick(); byte_stb = 1'b0;
    endtask
    task automatic do_stop();
        stop_stb = 1'b1; tick(); stop_stb = 1'b0;
    endtask
    task automatic idle(int n);
        for (int k = 0; k < n; k++) tick();
    endtask
    task automatic rd(int a, int exp, string tag);
        rd_addr = 11'(a); #1; chk(tag, int'(rd_data), exp);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL R5 watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        // R1 reset state
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 cur_addr after reset", int'(cur_addr), 0);
        rd(0, 8'hFF, "R1 erased 000");
        rd(11'h7FF, 8'hFF, "R1 erased 7FF");

        // R2/R3 short burst, R5 commit timing
        do_load(11'h123);
        chk("R2 cur_addr after load", int'(cur_addr), 11'h123);
        do_byte(8'hA1); do_byte(8'hA2); do_byte(8'hA3);
        chk("R3 cur_addr after 3 bytes", int'(cur_addr), 11'h126);
        rd(11'h123, 8'hFF, "R5 no change before stop");
        do_stop();
        chk("R5 busy after stop", int'(busy), 1);
        rd(11'h124, 8'hFF, "R10 old data readable while busy");
        // R6 strobes during busy
        do_load(11'h050); do_byte(8'h99); do_stop();
        chk("R6 cur_addr frozen while busy", int'(cur_addr), 11'h126);
        begin
            int n = 3;
            while (busy) begin tick(); n++; end
            chk("R5 busy length", n, WR);
        end
        rd(11'h123, 8'hA1, "R5 byte 0 committed");
        rd(11'h124, 8'hA2, "R5 byte 1 committed");
        rd(11'h125, 8'hA3, "R5 byte 2 committed");
        rd(11'h126, 8'hFF, "R5 untouched neighbour");
        rd(11'h050, 8'hFF, "R6 busy-time write dropped");
        idle(WR + 2);
        chk("R6 no late cycle", int'(busy), 0);

        // R4 wrap within page
        do_load(11'h2FE);
        for (int i = 0; i < 18; i++) do_byte(8'h10 + i);
        chk("R4 cur_addr stays in page", int'(cur_addr), 11'h2F0);
        do_stop();
        idle(WR + 1);
        rd(11'h2FE, 8'h20, "R4 offset E overwritten");
        rd(11'h2FF, 8'h21, "R4 offset F overwritten");
        rd(11'h2F0, 8'h12, "R4 offset 0 after wrap");
        rd(11'h300, 8'hFF, "R4 next page untouched");

        // R7 wp high for one middle cycle, then only at stop
        do_load(11'h400); do_byte(8'h55);
        wp = 1'b1; tick(); wp = 1'b0;
        do_byte(8'h66); do_stop();
        chk("R7 no busy after mid wp", int'(busy), 0);
        rd(11'h400, 8'hFF, "R7 array kept (mid wp)");
        do_load(11'h410); do_byte(8'h77);
        wp = 1'b1; rd_addr = 11'h123;
        do_stop();
        chk("R7 no busy with wp at stop", int'(busy), 0);
        rd(11'h123, 8'hA1, "R10 read with wp high");
        wp = 1'b0;
        idle(2);
        rd(11'h410, 8'hFF, "R7 array kept (wp at stop)");

        // R8 low supply at stop
        do_load(11'h420); do_byte(8'h88);
        supply_ok = 1'b0; do_stop(); supply_ok = 1'b1;
        chk("R8 no busy on low supply", int'(busy), 0);
        idle(2);
        rd(11'h420, 8'hFF, "R8 array kept");

        // R9 address-only stop
        do_load(11'h5A5); do_stop();
        chk("R9 no busy on empty stop", int'(busy), 0);
        chk("R9 cur_addr from dummy write", int'(cur_addr), 11'h5A5);

        // R11 bytes and stop with no open transaction
        do_byte(8'h44); do_byte(8'h45); do_stop();
        chk("R11 cur_addr unchanged", int'(cur_addr), 11'h5A5);
        chk("R11 no busy", int'(busy), 0);
        idle(WR + 1);
        rd(11'h5A5, 8'hFF, "R11 array unchanged");

        idle(2);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule